// File: doc/BRIEF.md
# Shared Status Alert Timeout Manager

This block drives one shared, active-low management alert line for several network ports. Each port answers at its own slave address on the management bus. When a port's status changes, the port raises a pending flag and asks for the alert. The flag is cleared in one of two ways. The host can read status at that port's address, or the port can give up after a programmable notification timeout, counted in millisecond ticks. A timeout value of zero means the port waits until it is read, however long that takes.

One timeout value is shared by all ports, but each port runs its own counter. A per-port reporting enable decides whether that port's pending flag may pull the shared line low. The pending flags are also brought out as a vector, so that the logic answering an alert-response query can tell which port is asking for service. Decoding of the bus bits is done elsewhere. This block sees only single-cycle strobes that have already been decoded.

Top module: `smb_alert_mgr`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, every bit of `pending_o` is 1. Each port thus starts with a status change logged.
- R2: A one-cycle pulse on bit i of `status_rd_i`, with no status change on port i in the same cycle, clears bit i of `pending_o` at the next clock edge.
- R3: A one-cycle pulse on bit i of `status_chg_i` sets bit i of `pending_o` at the next clock edge and restarts that port's timeout count from zero, even when the port is already pending.
- R4: With `timeout_ms_i` = T (T > 0), a pending port clears its flag at the clock edge of the T-th `ms_tick_i` pulse counted after the flag was last set or restarted. Before that edge the flag stays set.
- R5: When `timeout_ms_i` is 0, a pending flag is never cleared by ticks and stays set until it is read, however many ticks arrive.
- R6: A single `timeout_ms_i` applies to every port. Each port counts its own ticks from its own last status change.
- R7: `alert_n_o` is 0 exactly when some port i has both bit i of `pending_o` and bit i of `report_en_i` set. It is combinational in those bits. Clearing an enable has no effect on that port's pending flag.
- R8: A status read and a timeout expiry on the same port in the same cycle leave the flag cleared. It stays cleared on the cycles that follow.
- R9: A status change and a status read on the same port in the same cycle leave the flag set, with the count restarted.
- R10: `pending_o` gives each port's flag on its own bit, bit i for port i, so that the port asking for service can be identified.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| timeout_ms_i | input | TMO_W (8) | Shared notification timeout in ms; 0 means infinite |
| status_chg_i | input | NUM_PORTS (2) | Per-port status-change pulse |
| status_rd_i | input | NUM_PORTS (2) | Per-port status-read strobe, decoded from the slave address |
| report_en_i | input | NUM_PORTS (2) | Per-port permission to drive the alert |
| alert_n_o | output | 1 | Shared alert, active low |
| pending_o | output | NUM_PORTS (2) | Per-port pending flags |

## Verification
The assertions take for granted that strobes and ticks last one cycle each. They also assume that `timeout_ms_i` changes only while no port is part way through a count that the change would cut short. The stimulus drives every strobe high for exactly one clock and then drops it. It changes the timeout value only right after reset, or after a read has cleared the ports concerned. All inputs change a little after the rising edge, so each edge samples stable values.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;

  // Expiry fires on the tick that would bring the elapsed count up to the limit.
  function automatic logic tmo_hit(input logic [15:0] elapsed, input logic [15:0] limit);
    return (limit != 16'd0) && ((elapsed + 16'd1) >= limit);
  endfunction

  // Saturating increment so an idle counter can never wrap.
  function automatic logic [15:0] sat_inc(input logic [15:0] v, input logic [15:0] max_v);
    return (v >= max_v) ? max_v : v + 16'd1;
  endfunction

endpackage

// File: rtl/alert_port_slot.sv
module alert_port_slot
  import smb_alert_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [TMO_W-1:0] limit_i,
  input  logic             chg_i,
  input  logic             rd_i,
  output logic             pend_o,
  output logic             expire_o
);
  localparam logic [15:0] CNT_MAX = 16'((1 << TMO_W) - 1);

  logic             pend_q;
  logic [TMO_W-1:0] cnt_q;
  logic [15:0]      cnt_ext, lim_ext;

  assign cnt_ext  = 16'(cnt_q);
  assign lim_ext  = 16'(limit_i);
  assign expire_o = pend_q && tick_i && tmo_hit(cnt_ext, lim_ext);
  assign pend_o   = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
    end else if (chg_i) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
    end else if (rd_i || expire_o) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (pend_q && tick_i && (limit_i != '0)) begin
      cnt_q  <= TMO_W'(sat_inc(cnt_ext, CNT_MAX));
    end
  end

  // R2
  rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !chg_i) |=> !pend_q);
  // R3
  chg_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_i |=> pend_q);
  // R5
  zero_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && (limit_i == '0) && !rd_i) |=> pend_q);
  // R8
  expire_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> (pend_q && tick_i && (limit_i != '0)));
  // R8
  rd_expire_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && rd_i && !chg_i) |=> !pend_q);
endmodule

// File: rtl/alert_merge.sv
module alert_merge #(
  parameter int NUM_PORTS = 2
) (
  input  logic [NUM_PORTS-1:0] pend_i,
  input  logic [NUM_PORTS-1:0] en_i,
  output logic                 alert_n_o
);
  logic [NUM_PORTS-1:0] req;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_req
    assign req[g] = pend_i[g] & en_i[g];
  end

  assign alert_n_o = ~(|req);
endmodule

// File: rtl/smb_alert_mgr.sv
module smb_alert_mgr #(
  parameter int NUM_PORTS = 2,
  parameter int TMO_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ms_tick_i,
  input  logic [TMO_W-1:0]     timeout_ms_i,
  input  logic [NUM_PORTS-1:0] status_chg_i,
  input  logic [NUM_PORTS-1:0] status_rd_i,
  input  logic [NUM_PORTS-1:0] report_en_i,
  output logic                 alert_n_o,
  output logic [NUM_PORTS-1:0] pending_o
);
  logic [NUM_PORTS-1:0] slot_pend;
  logic [NUM_PORTS-1:0] slot_expire;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_slot
    alert_port_slot #(.TMO_W(TMO_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (ms_tick_i),
      .limit_i  (timeout_ms_i),
      .chg_i    (status_chg_i[p]),
      .rd_i     (status_rd_i[p]),
      .pend_o   (slot_pend[p]),
      .expire_o (slot_expire[p])
    );
  end

  alert_merge #(.NUM_PORTS(NUM_PORTS)) u_merge (
    .pend_i    (slot_pend),
    .en_i      (report_en_i),
    .alert_n_o (alert_n_o)
  );

  assign pending_o = slot_pend;

  // R7
  alert_when_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(slot_pend & report_en_i)) |-> !alert_n_o);
  // R7
  quiet_when_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_pend & report_en_i) == '0) |-> alert_n_o);
  // R5
  no_expire_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_ms_i == '0) |-> (slot_expire == '0));
endmodule

// File: tb/smb_alert_mgr_tb.sv
module smb_alert_mgr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [TW-1:0] tmo = '0;
  logic [NP-1:0] chg = '0;
  logic [NP-1:0] rd = '0;
  logic [NP-1:0] en = '1;
  logic          alert_n;
  logic [NP-1:0] pend;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_alert_mgr #(.NUM_PORTS(NP), .TMO_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ms_tick_i(tick), .timeout_ms_i(tmo),
    .status_chg_i(chg), .status_rd_i(rd), .report_en_i(en),
    .alert_n_o(alert_n), .pending_o(pend)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic pulse(input logic [NP-1:0] c, input logic [NP-1:0] r, input logic t);
    chg = c; rd = r; tick = t;
    cyc();
    chg = '0; rd = '0; tick = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; chg = '0; rd = '0; tick = 1'b0;
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic t_reset();
    en = 2'b11; tmo = '0;
    rst_n = 1'b0; cyc();
    chk("R1 pend in reset", 8'(pend), 8'h3);
    rst_n = 1'b1; cyc();
    chk("R1 pend after reset", 8'(pend), 8'h3);
    chk("R1 alert after reset", 8'(alert_n), 8'h0);
  endtask

  task automatic t_read();
    do_reset();
    pulse(2'b01, 2'b00, 1'b0); // keep port0 fresh
    pulse(2'b00, 2'b10, 1'b0);
    chk("R2 read port1", 8'(pend), 8'h1);
    chk("R10 which port", 8'(pend[0]), 8'h1);
    pulse(2'b00, 2'b01, 1'b0);
    chk("R2 read port0", 8'(pend), 8'h0);
    chk("R7 alert idle", 8'(alert_n), 8'h1);
    pulse(2'b10, 2'b00, 1'b0);
    chk("R3 change sets", 8'(pend), 8'h2);
  endtask

  task automatic t_timeout();
    tmo = 8'd3;
    do_reset();
    pulse(2'b00, 2'b10, 1'b0);
    pulse(2'b00, 2'b00, 1'b1);
    pulse(2'b00, 2'b00, 1'b1);
    chk("R4 before expiry", 8'(pend), 8'h1);
    pulse(2'b00, 2'b00, 1'b0);
    chk("R4 no tick no expiry", 8'(pend), 8'h1);
    pulse(2'b00, 2'b00, 1'b1);
    chk("R4 expiry on 3rd tick", 8'(pend), 8'h0);
    chk("R4 alert released", 8'(alert_n), 8'h1);
  endtask

  task automatic t_restart_shared();
    tmo = 8'd3;
    do_reset();
    pulse(2'b00, 2'b00, 1'b1);
    pulse(2'b00, 2'b00, 1'b1);
    pulse(2'b01, 2'b00, 1'b0); // restart port0 only
    pulse(2'b00, 2'b00, 1'b1);
    chk("R6 port1 expired, port0 held", 8'(pend), 8'h1);
    pulse(2'b00, 2'b00, 1'b1);
    chk("R3 restarted count", 8'(pend), 8'h1);
    pulse(2'b00, 2'b00, 1'b1);
    chk("R3 expires after restart", 8'(pend), 8'h0);
  endtask

  task automatic t_zero();
    tmo = 8'd0;
    do_reset();
    for (int i = 0; i < 300; i++) pulse(2'b00, 2'b00, 1'b1);
    chk("R5 infinite timeout", 8'(pend), 8'h3);
    pulse(2'b00, 2'b11, 1'b0);
    chk("R5 cleared by read", 8'(pend), 8'h0);
  endtask

  task automatic t_enable();
    tmo = 8'd0;
    do_reset();
    en = 2'b01;
    pulse(2'b00, 2'b01, 1'b0);
    chk("R7 masked port1 no alert", 8'(alert_n), 8'h1);
    chk("R7 masked flag kept", 8'(pend), 8'h2);
    en = 2'b11; #1;
    chk("R7 enable asserts alert", 8'(alert_n), 8'h0);
    en = 2'b00; #1;
    chk("R7 all masked", 8'(alert_n), 8'h1);
    en = 2'b11;
  endtask

  task automatic t_same_cycle();
    tmo = 8'd2;
    do_reset();
    pulse(2'b00, 2'b00, 1'b1);
    pulse(2'b00, 2'b01, 1'b1); // port0 read + expiry, port1 expiry
    chk("R8 read and expiry", 8'(pend), 8'h0);
    pulse(2'b00, 2'b00, 1'b1);
    chk("R8 stays cleared", 8'(pend), 8'h0);
    pulse(2'b01, 2'b01, 1'b0);
    chk("R9 change beats read", 8'(pend), 8'h1);
    pulse(2'b00, 2'b00, 1'b1);
    chk("R9 count restarted", 8'(pend), 8'h1);
    pulse(2'b00, 2'b00, 1'b1);
    chk("R9 expires after restart", 8'(pend), 8'h0);
  endtask

  initial begin
    t_reset();
    t_read();
    t_timeout();
    t_restart_shared();
    t_zero();
    t_enable();
    t_same_cycle();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule